// File: doc/BRIEF.md
# Serial Channel Control Register Front End

This block is the host-facing control register logic for one channel of an asynchronous serial controller. The host reaches a bank of eight write registers through one byte-wide port. A three-bit pointer kept in register 0 chooses the target of each write. After any access to a non-zero register the pointer returns to 0, so the next byte is always taken as a pointer, command or both.

Register 0 also carries a command field. Commands resample the modem status, clear receive errors, reset the channel, or send one-cycle event pulses to the neighbouring transmit, receive and interrupt logic. The block holds the read-status bytes and drives the active-low RTS and DTR modem lines. RTS release is deferred until the transmitter reports that it has fully drained. The shift registers, baud generation and interrupt chain sit elsewhere and connect through the ports below.

Top module: `sio_ctl_regs`

## Requirements
- R1: Bits 2:0 of register 0 form the pointer that selects the target of each write. A write to any register other than 0 returns the pointer to 0, so the following byte lands in register 0.
- R2: Writes to registers 1 to 5 are stored and appear on `cfg_wr1`, `cfg_wr3`, `cfg_wr4` and `cfg_wr5` after the clock edge. Register 6 loads bits 7:0 of `sync_word` and register 7 loads bits 15:8.
- R3: Bits 5:3 of a register 0 write are a command: 0 null, 1 abort, 2 status resample, 3 channel reset, 4 arm next-receive interrupt, 5 transmit interrupt acknowledge, 6 error reset, 7 interrupt return. Codes 1, 4, 5 and 7 raise `cmd_evt` bit 0, 1, 2 and 3 respectively, combinationally in the strobe cycle. At most one bit of `cmd_evt` is high at a time.
- R4: Command 2 clears `rr0` bit 7 (break) and reloads bit 3 with the inverse of `dcd_in`, bit 4 with `ri_in` and bit 5 with `cts_in`. Between commands these bits hold their value whatever the inputs do. A `rx_break` pulse sets bit 7.
- R5: Pulses on `rx_parity_err`, `rx_overrun_err` and `rx_frame_err` set `rr1` bits 4, 5 and 6, and these bits stay set. Command 6 clears all three bits and takes priority over events in the same cycle. It leaves `rr1` bit 0 unchanged.
- R6: Writing register 5 with bit 1 set drives `rts_n` low after the clock edge.
- R7: Writing register 5 with bit 1 clear keeps `rts_n` low until a `tx_empty` pulse arrives in a later cycle. Setting bit 1 again before that pulse cancels the pending release.
- R8: `dtr_n` is the inverse of register 5 bit 7.
- R9: Hardware reset clears all registers. Command 3 clears register 3 bit 0 and register 5 bits 7, 3 and 1. Both set `rr0` bit 2 (transmit buffer empty) and `rr1` bit 0 (all sent) and leave `rts_n` and `dtr_n` high.
- R10: A `tx_load` pulse clears `rr0` bit 2 and `rr1` bit 0. A `tx_empty` pulse sets them again and wins over a `tx_load` pulse in the same cycle.
- R11: With `VEC_CHAN` = 1, a register 2 write is kept and `rr2` returns written bits 7:4 and 0, with `vec_status` in bits 3:1. With `VEC_CHAN` = 0 the write has no effect on `rr2`, which shows zeros around `vec_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_data | input | 8 | Host write byte |
| dcd_in | input | 1 | Carrier detect input (low means carrier present) |
| cts_in | input | 1 | Clear-to-send input |
| ri_in | input | 1 | Ring indicator input |
| rx_break | input | 1 | Break detected pulse |
| rx_parity_err | input | 1 | Parity error pulse |
| rx_overrun_err | input | 1 | Overrun pulse |
| rx_frame_err | input | 1 | Framing/CRC error pulse |
| tx_load | input | 1 | Transmitter accepted a byte |
| tx_empty | input | 1 | Transmitter fully drained |
| vec_status | input | 3 | Status code merged into the vector readback |
| cfg_wr1 | output | 8 | Register 1 contents |
| cfg_wr3 | output | 8 | Register 3 contents |
| cfg_wr4 | output | 8 | Register 4 contents |
| cfg_wr5 | output | 8 | Register 5 contents |
| sync_word | output | 16 | Sync value |
| rr0 | output | 8 | Read status 0 |
| rr1 | output | 8 | Read status 1 |
| rr2 | output | 8 | Vector readback |
| cmd_evt | output | 4 | Command event pulses |
| rts_n | output | 1 | Active-low RTS |
| dtr_n | output | 1 | Active-low DTR |

## Verification
On every cycle the assertions check the following:
- the pointer returns to 0 after a non-zero access;
- the command pulses are mutually exclusive;
- error reset clears the error bits;
- RTS assertion is immediate and its release only ever follows a drain pulse or a channel reset;
- DTR tracks register 5 writes;
- channel reset brings the lines and status bits to their defaults.

Some behaviours need chosen input sequences and are shown only by the bench's scenarios:
- the status bits stay latched while the modem inputs move between commands;
- a re-assertion cancels a pending RTS release;
- the sync bytes go to the correct halves;
- the vector readback merges the written bits with the status.

// File: rtl/sio_ctl_pkg.sv
package sio_ctl_pkg;
    localparam int BYTE_W  = 8;
    localparam int NUM_WR  = 8;
    localparam int PTR_W   = $clog2(NUM_WR);
    localparam int CMD_LSB = PTR_W;
    localparam int EVT_W   = 4;

    typedef enum logic [2:0] {
        CMD_NULL     = 3'd0,
        CMD_ABORT    = 3'd1,
        CMD_STAT_RST = 3'd2,
        CMD_CHAN_RST = 3'd3,
        CMD_RX_NEXT  = 3'd4,
        CMD_TX_ACK   = 3'd5,
        CMD_ERR_RST  = 3'd6,
        CMD_RETI     = 3'd7
    } cmd_e;

    typedef struct packed {
        logic             chan_rst;
        logic             stat_rst;
        logic             err_rst;
        logic [EVT_W-1:0] evt;
    } cmd_dec_t;

    // Bit positions decoded by neighbouring logic
    localparam int W3_RX_EN  = 0;
    localparam int W5_RTS    = 1;
    localparam int W5_TX_EN  = 3;
    localparam int W5_DTR    = 7;
    localparam int S0_TXE    = 2;
    localparam int S0_DCD    = 3;
    localparam int S0_RI     = 4;
    localparam int S0_CTS    = 5;
    localparam int S0_BRK    = 7;
    localparam int S1_ALLS   = 0;
    localparam int S1_PAR    = 4;
    localparam int S1_OVR    = 5;
    localparam int S1_FRM    = 6;

    function automatic logic [EVT_W-1:0] evt_of(input cmd_e c);
        logic [EVT_W-1:0] e;
        e = '0;
        case (c)
            CMD_ABORT:   e[0] = 1'b1;
            CMD_RX_NEXT: e[1] = 1'b1;
            CMD_TX_ACK:  e[2] = 1'b1;
            CMD_RETI:    e[3] = 1'b1;
            default:     e = '0;
        endcase
        return e;
    endfunction
endpackage

// File: rtl/sio_ptr_decode.sv
module sio_ptr_decode
    import sio_ctl_pkg::*;
(
    input  logic                 wr_stb,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic [PTR_W-1:0]     ptr_q,
    output logic [NUM_WR-1:0]    wr_sel,
    output cmd_dec_t             cmd
);
    cmd_e code;

    for (genvar i = 0; i < NUM_WR; i++) begin : g_sel
        assign wr_sel[i] = wr_stb && (ptr_q == PTR_W'(i));
    end

    assign code = cmd_e'(wr_data[CMD_LSB +: 3]);

    always_comb begin
        cmd = '0;
        if (wr_sel[0]) begin
            cmd.chan_rst = (code == CMD_CHAN_RST);
            cmd.stat_rst = (code == CMD_STAT_RST);
            cmd.err_rst  = (code == CMD_ERR_RST);
            cmd.evt      = evt_of(code);
        end
    end
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_ctl_pkg::*;
#(
    parameter bit VEC_CHAN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WR-1:0]    wr_sel,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic                 chan_rst,
    input  logic [2:0]           vec_status,
    output logic [PTR_W-1:0]     ptr_q,
    output logic [BYTE_W-1:0]    cfg_wr1,
    output logic [BYTE_W-1:0]    cfg_wr3,
    output logic [BYTE_W-1:0]    cfg_wr4,
    output logic [BYTE_W-1:0]    cfg_wr5,
    output logic [2*BYTE_W-1:0]  sync_word,
    output logic [BYTE_W-1:0]    rr2
);
    logic [BYTE_W-1:0]   cfg_q [1:5];
    logic [2*BYTE_W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            sync_q <= '0;
            for (int i = 1; i <= 5; i++) cfg_q[i] <= '0;
        end else begin
            if (wr_sel[0])
                ptr_q <= wr_data[PTR_W-1:0];
            else if (|wr_sel)
                ptr_q <= '0;
            for (int i = 1; i <= 5; i++)
                if (wr_sel[i]) cfg_q[i] <= wr_data;
            if (wr_sel[6]) sync_q[BYTE_W-1:0]        <= wr_data;
            if (wr_sel[7]) sync_q[2*BYTE_W-1:BYTE_W] <= wr_data;
            if (chan_rst) begin
                cfg_q[3][W3_RX_EN] <= 1'b0;
                cfg_q[5][W5_TX_EN] <= 1'b0;
                cfg_q[5][W5_RTS]   <= 1'b0;
                cfg_q[5][W5_DTR]   <= 1'b0;
            end
        end
    end

    if (VEC_CHAN) begin : g_vec_live
        logic [4:0] vec_q;
        always_ff @(posedge clk) begin
            if (rst)            vec_q <= '0;
            else if (wr_sel[2]) vec_q <= {wr_data[7:4], wr_data[0]};
        end
        assign rr2 = {vec_q[4:1], vec_status, vec_q[0]};
    end else begin : g_vec_dead
        assign rr2 = {4'b0000, vec_status, 1'b0};
    end

    assign cfg_wr1   = cfg_q[1];
    assign cfg_wr3   = cfg_q[3];
    assign cfg_wr4   = cfg_q[4];
    assign cfg_wr5   = cfg_q[5];
    assign sync_word = sync_q;
endmodule

// File: rtl/sio_status_regs.sv
module sio_status_regs
    import sio_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_rst,
    input  logic              err_rst,
    input  logic              chan_rst,
    input  logic              dcd_in,
    input  logic              cts_in,
    input  logic              ri_in,
    input  logic              rx_break,
    input  logic              rx_parity_err,
    input  logic              rx_overrun_err,
    input  logic              rx_frame_err,
    input  logic              tx_load,
    input  logic              tx_empty,
    output logic [BYTE_W-1:0] rr0,
    output logic [BYTE_W-1:0] rr1
);
    logic dcd_q, ri_q, cts_q, brk_q, txe_q;
    logic par_q, ovr_q, frm_q, alls_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            {dcd_q, ri_q, cts_q, brk_q} <= '0;
            {par_q, ovr_q, frm_q}       <= '0;
            txe_q  <= 1'b1;
            alls_q <= 1'b1;
        end else begin
            if (stat_rst) begin
                dcd_q <= ~dcd_in;
                ri_q  <= ri_in;
                cts_q <= cts_in;
                brk_q <= 1'b0;
            end else if (rx_break) begin
                brk_q <= 1'b1;
            end
            if (err_rst) begin
                {par_q, ovr_q, frm_q} <= '0;
            end else begin
                if (rx_parity_err)  par_q <= 1'b1;
                if (rx_overrun_err) ovr_q <= 1'b1;
                if (rx_frame_err)   frm_q <= 1'b1;
            end
            if (chan_rst || tx_empty) begin
                txe_q  <= 1'b1;
                alls_q <= 1'b1;
            end else if (tx_load) begin
                txe_q  <= 1'b0;
                alls_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rr0         = '0;
        rr0[S0_TXE] = txe_q;
        rr0[S0_DCD] = dcd_q;
        rr0[S0_RI]  = ri_q;
        rr0[S0_CTS] = cts_q;
        rr0[S0_BRK] = brk_q;
        rr1          = '0;
        rr1[S1_ALLS] = alls_q;
        rr1[S1_PAR]  = par_q;
        rr1[S1_OVR]  = ovr_q;
        rr1[S1_FRM]  = frm_q;
    end
endmodule

// File: rtl/sio_rts_ctl.sv
module sio_rts_ctl (
    input  logic clk,
    input  logic rst,
    input  logic wr5_sel,
    input  logic rts_bit,
    input  logic chan_rst,
    input  logic tx_empty,
    output logic rts_n
);
    logic release_pend;

    always_ff @(posedge clk) begin
        if (rst || chan_rst) begin
            rts_n        <= 1'b1;
            release_pend <= 1'b0;
        end else if (wr5_sel) begin
            if (rts_bit) begin
                rts_n        <= 1'b0;
                release_pend <= 1'b0;
            end else if (!rts_n) begin
                release_pend <= 1'b1;
            end
        end else if (release_pend && tx_empty) begin
            rts_n        <= 1'b1;
            release_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/sio_ctl_regs.sv
module sio_ctl_regs
    import sio_ctl_pkg::*;
#(
    parameter bit VEC_CHAN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_stb,
    input  logic [7:0]           wr_data,
    input  logic                 dcd_in,
    input  logic                 cts_in,
    input  logic                 ri_in,
    input  logic                 rx_break,
    input  logic                 rx_parity_err,
    input  logic                 rx_overrun_err,
    input  logic                 rx_frame_err,
    input  logic                 tx_load,
    input  logic                 tx_empty,
    input  logic [2:0]           vec_status,
    output logic [7:0]           cfg_wr1,
    output logic [7:0]           cfg_wr3,
    output logic [7:0]           cfg_wr4,
    output logic [7:0]           cfg_wr5,
    output logic [15:0]          sync_word,
    output logic [7:0]           rr0,
    output logic [7:0]           rr1,
    output logic [7:0]           rr2,
    output logic [3:0]           cmd_evt,
    output logic                 rts_n,
    output logic                 dtr_n
);
    logic [PTR_W-1:0]  ptr_q;
    logic [NUM_WR-1:0] wr_sel;
    cmd_dec_t          cmd;

    sio_ptr_decode u_dec (
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .ptr_q   (ptr_q),
        .wr_sel  (wr_sel),
        .cmd     (cmd)
    );

    sio_cfg_regs #(.VEC_CHAN(VEC_CHAN)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .chan_rst   (cmd.chan_rst),
        .vec_status (vec_status),
        .ptr_q      (ptr_q),
        .cfg_wr1    (cfg_wr1),
        .cfg_wr3    (cfg_wr3),
        .cfg_wr4    (cfg_wr4),
        .cfg_wr5    (cfg_wr5),
        .sync_word  (sync_word),
        .rr2        (rr2)
    );

    sio_status_regs u_stat (
        .clk            (clk),
        .rst            (rst),
        .stat_rst       (cmd.stat_rst),
        .err_rst        (cmd.err_rst),
        .chan_rst       (cmd.chan_rst),
        .dcd_in         (dcd_in),
        .cts_in         (cts_in),
        .ri_in          (ri_in),
        .rx_break       (rx_break),
        .rx_parity_err  (rx_parity_err),
        .rx_overrun_err (rx_overrun_err),
        .rx_frame_err   (rx_frame_err),
        .tx_load        (tx_load),
        .tx_empty       (tx_empty),
        .rr0            (rr0),
        .rr1            (rr1)
    );

    sio_rts_ctl u_rts (
        .clk      (clk),
        .rst      (rst),
        .wr5_sel  (wr_sel[5]),
        .rts_bit  (wr_data[W5_RTS]),
        .chan_rst (cmd.chan_rst),
        .tx_empty (tx_empty),
        .rts_n    (rts_n)
    );

    assign cmd_evt = cmd.evt;
    assign dtr_n   = ~cfg_wr5[W5_DTR];
endmodule

// File: rtl/sio_ctl_checker.sv
module sio_ctl_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_stb,
    input logic [7:0] wr_data,
    input logic [2:0] ptr_q,
    input logic       chan_rst,
    input logic       err_rst,
    input logic       tx_empty,
    input logic [3:0] cmd_evt,
    input logic [7:0] rr0,
    input logic [7:0] rr1,
    input logic [7:0] cfg_wr3,
    input logic [7:0] cfg_wr5,
    input logic       rts_n,
    input logic       dtr_n
);
    AST_PTR_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && ptr_q != 3'd0) |=> (ptr_q == 3'd0)); // R1

    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_evt)); // R3

    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        err_rst |=> (rr1[6:4] == 3'b000)); // R5

    AST_RTS_ASSERT: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && ptr_q == 3'd5 && wr_data[1]) |=> !rts_n); // R6

    AST_RTS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(rts_n) |-> ($past(tx_empty) || $past(chan_rst))); // R7

    AST_DTR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && ptr_q == 3'd5) |=> (dtr_n == !$past(wr_data[7]))); // R8

    AST_CHAN_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        chan_rst |=> (rts_n && dtr_n && !cfg_wr3[0] && !cfg_wr5[3] && rr0[2] && rr1[0])); // R9
endmodule

bind sio_ctl_regs sio_ctl_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .ptr_q    (ptr_q),
    .chan_rst (cmd.chan_rst),
    .err_rst  (cmd.err_rst),
    .tx_empty (tx_empty),
    .cmd_evt  (cmd_evt),
    .rr0      (rr0),
    .rr1      (rr1),
    .cfg_wr3  (cfg_wr3),
    .cfg_wr5  (cfg_wr5),
    .rts_n    (rts_n),
    .dtr_n    (dtr_n)
);

// File: tb/sio_ctl_regs_tb.sv
module sio_ctl_regs_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        dcd_in = 1'b1, cts_in = 1'b0, ri_in = 1'b0;
    logic        rx_break = 1'b0, rx_parity_err = 1'b0;
    logic        rx_overrun_err = 1'b0, rx_frame_err = 1'b0;
    logic        tx_load = 1'b0, tx_empty = 1'b0;
    logic [2:0]  vec_status = '0;
    logic [7:0]  cfg_wr1, cfg_wr3, cfg_wr4, cfg_wr5, rr0, rr1, rr2;
    logic [15:0] sync_word;
    logic [3:0]  cmd_evt;
    logic        rts_n, dtr_n;
    int          n_chk = 0;
    int          n_bad = 0;
    logic [3:0]  evt_seen;

    always #10 clk = ~clk;

    sio_ctl_regs u_dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
        .dcd_in(dcd_in), .cts_in(cts_in), .ri_in(ri_in), .rx_break(rx_break),
        .rx_parity_err(rx_parity_err), .rx_overrun_err(rx_overrun_err),
        .rx_frame_err(rx_frame_err), .tx_load(tx_load), .tx_empty(tx_empty),
        .vec_status(vec_status), .cfg_wr1(cfg_wr1), .cfg_wr3(cfg_wr3),
        .cfg_wr4(cfg_wr4), .cfg_wr5(cfg_wr5), .sync_word(sync_word),
        .rr0(rr0), .rr1(rr1), .rr2(rr2), .cmd_evt(cmd_evt),
        .rts_n(rts_n), .dtr_n(dtr_n)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = d;
        #1 evt_seen = cmd_evt;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic wr_reg(input logic [2:0] idx, input logic [7:0] d);
        wr_byte({5'b00000, idx});
        wr_byte(d);
    endtask

    task automatic pulse_empty();
        @(negedge clk); tx_empty = 1'b1;
        @(negedge clk); tx_empty = 1'b0;
    endtask

    task automatic pulse_load();
        @(negedge clk); tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 reset rr0", {8'h0, rr0}, 16'h0004);
        check("R9 reset rr1", {8'h0, rr1}, 16'h0001);
        check("R9 reset lines", {14'h0, rts_n, dtr_n}, 16'h0003);
        check("R2 reset cfg", {cfg_wr3, cfg_wr5}, 16'h0000);
        check("R2 reset sync", sync_word, 16'h0000);
    endtask

    task automatic t_pointer();
        wr_reg(3'd1, 8'hA5);
        wr_reg(3'd3, 8'h3C);
        wr_reg(3'd4, 8'h5A);
        check("R2 wr1", {8'h0, cfg_wr1}, 16'h00A5);
        check("R2 wr3/wr4", {cfg_wr3, cfg_wr4}, 16'h3C5A);
        wr_byte(8'h00);
        check("R1 byte after access goes to reg0", {8'h0, cfg_wr1}, 16'h00A5);
        wr_reg(3'd6, 8'h34);
        wr_reg(3'd7, 8'h12);
        check("R2 sync word", sync_word, 16'h1234);
    endtask

    task automatic t_commands();
        wr_byte(8'h08); check("R3 abort evt", {12'h0, evt_seen}, 16'h0001);
        wr_byte(8'h20); check("R3 rx-next evt", {12'h0, evt_seen}, 16'h0002);
        wr_byte(8'h28); check("R3 tx-ack evt", {12'h0, evt_seen}, 16'h0004);
        wr_byte(8'h38); check("R3 reti evt", {12'h0, evt_seen}, 16'h0008);
        wr_byte(8'h00); check("R3 null evt", {12'h0, evt_seen}, 16'h0000);
        check("R3 evt idle", {12'h0, cmd_evt}, 16'h0000);
    endtask

    task automatic t_ext_status();
        dcd_in = 1'b0; ri_in = 1'b1; cts_in = 1'b0;
        @(negedge clk); rx_break = 1'b1;
        @(negedge clk); rx_break = 1'b0;
        check("R4 break latched, modem bits held", {8'h0, rr0}, 16'h0084);
        wr_byte(8'h10);
        check("R4 resample 1", {8'h0, rr0}, 16'h001C);
        dcd_in = 1'b1; cts_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R4 latched between commands", {8'h0, rr0}, 16'h001C);
        wr_byte(8'h10);
        check("R4 resample 2", {8'h0, rr0}, 16'h0034);
    endtask

    task automatic t_errors();
        @(negedge clk); rx_parity_err = 1'b1; rx_overrun_err = 1'b1; rx_frame_err = 1'b1;
        @(negedge clk); rx_parity_err = 1'b0; rx_overrun_err = 1'b0; rx_frame_err = 1'b0;
        check("R5 errors set", {8'h0, rr1}, 16'h0071);
        pulse_load();
        check("R10 load clears rr1 bit0", {8'h0, rr1}, 16'h0070);
        check("R10 load clears rr0 bit2", {15'h0, rr0[2]}, 16'h0000);
        wr_byte(8'h30);
        check("R5 error reset keeps bit0", {8'h0, rr1}, 16'h0000);
        pulse_empty();
        check("R10 empty sets status", {8'h0, rr1[7:0]} | {15'h0, rr0[2]} << 8, 16'h0101);
    endtask

    task automatic t_rts();
        wr_reg(3'd5, 8'h82);
        check("R6 rts low", {15'h0, rts_n}, 16'h0000);
        check("R8 dtr low", {15'h0, dtr_n}, 16'h0000);
        wr_reg(3'd5, 8'h80);
        repeat (3) @(negedge clk);
        check("R7 rts held until empty", {15'h0, rts_n}, 16'h0000);
        wr_reg(3'd5, 8'h82);
        pulse_empty();
        check("R7 re-assert cancels release", {15'h0, rts_n}, 16'h0000);
        wr_reg(3'd5, 8'h00);
        check("R8 dtr high", {15'h0, dtr_n}, 16'h0001);
        check("R7 rts still low", {15'h0, rts_n}, 16'h0000);
        pulse_empty();
        check("R7 rts released", {15'h0, rts_n}, 16'h0001);
    endtask

    task automatic t_chan_reset();
        wr_reg(3'd3, 8'hC1);
        wr_reg(3'd5, 8'h8A);
        pulse_load();
        check("R9 pre lines", {14'h0, rts_n, dtr_n}, 16'h0000);
        wr_byte(8'h18);
        check("R9 chan wr3", {8'h0, cfg_wr3}, 16'h00C0);
        check("R9 chan wr5", {8'h0, cfg_wr5}, 16'h0000);
        check("R9 chan lines", {14'h0, rts_n, dtr_n}, 16'h0003);
        check("R9 chan status", {15'h0, rr0[2]} << 8 | {15'h0, rr1[0]}, 16'h0101);
        check("R9 chan keeps wr4", {8'h0, cfg_wr4}, 16'h005A);
    endtask

    task automatic t_vector();
        vec_status = 3'b010;
        wr_reg(3'd2, 8'hFF);
        check("R11 vector readback", {8'h0, rr2}, 16'h00F5);
        vec_status = 3'b101;
        #1 check("R11 status merge", {8'h0, rr2}, 16'h00FB);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pointer();
        t_commands();
        t_ext_status();
        t_errors();
        t_rts();
        t_chan_reset();
        t_vector();
        repeat (2) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule